// File: doc/BRIEF.md
# Per-Device Serial Clock and Chip-Select Timing Generator

This block times the framing of a serial peripheral transfer for up to eight attached devices. It keeps one 32-bit configuration word per device. Each word holds a clock rate scaler and three framing counts. When a transfer is launched, the block copies the chosen device's word into working registers. It then drives that device's active-low select line and waits out a setup interval. Next it toggles the serial clock for the requested number of bits, waits a hold interval and releases the select line. Finally it keeps `busy_o` high through a deselect gap before it accepts the next launch.

The serial clock rate is the reference clock times scaler/512. The scaler is a power of two from 1 to 128, so the serial clock runs between ref/512 and ref/4. A phase accumulator produces one strobe per serial half-period, and every other timing event is counted in those strobes. A data shifter, which is not part of this block, follows `bit_tick_o`, which marks the end of every bit. The shifter uses the same half-period grid.

Top module: `spi_cs_timing_gen`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` into the word of device `cfg_idx_i`. `cfg_rdata_o` shows the stored word of device `cfg_idx_i` combinationally. The field layout is: scaler in bits 31:24, setup count in 23:16, hold count in 15:8 and deselect-gap count in 7:0.
- R2: A written scaler that is not a power of two is stored rounded down to the highest power of two it contains. A written scaler of zero is stored as 1. The other 24 bits are stored unchanged.
- R3: With a stored scaler s, one serial half-period lasts H = 256/s reference cycles. Successive serial clock edges within a transfer are exactly H cycles apart.
- R4: `start_i` sampled high while idle launches a transfer for device `dev_sel_i`, using that device's word at that moment. From the same clock edge only `cs_n_o[dev_sel_i]` is driven low, and all other select lines stay high.
- R5: A count field c stands for max(c,1) half-periods. The first serial clock edge comes (setup'+1)·H cycles after the select line falls.
- R6: A transfer of N bits (N = 0 is treated as 1) makes exactly 2N serial clock edges and N `bit_tick_o` pulses. Each pulse is one cycle long and falls in the cycle in which the clock returns to its idle level.
- R7: The select line stays low for (setup' + 2N + hold')·H cycles in total, so it rises hold'·H cycles after the last clock edge.
- R8: `busy_o` is high for (setup' + 2N + hold' + gap')·H cycles, starting at the launch edge. A `start_i` pulse while `busy_o` is high is ignored.
- R9: The serial clock rests at the level given by `cpol_i` at launch during setup, hold, the gap and idle. It changes only while a select line is low.
- R10: A configuration write made during a transfer, even to the active device, does not change that transfer's timing.
- R11: After reset all select lines are high, `sclk_o`, `bit_tick_o` and `busy_o` are low, and every device word reads 32'h8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_idx_i | input | 3 | Device index for configuration write and readback |
| cfg_wdata_i | input | 32 | Configuration word to store |
| cfg_rdata_o | output | 32 | Stored word of device `cfg_idx_i` |
| start_i | input | 1 | Transfer launch request |
| dev_sel_i | input | 3 | Device addressed by the launch |
| nbits_i | input | 16 | Bit count of the launched transfer |
| cpol_i | input | 1 | Idle level of the serial clock for the launched transfer |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 8 | Active-low device select lines |
| bit_tick_o | output | 1 | End-of-bit strobe for the shift engine |
| busy_o | output | 1 | High from select assertion until the gap ends |

## Verification
The checker watches framing invariants on every cycle. At most one select line is low, and a low select line implies `busy_o`. `busy_o` rises only after a launch and falls only with every select line high. The serial clock and the bit strobe move only inside a frame, and every stored scaler reads back as a single set bit. The exact cycle counts cannot be checked cycle by cycle and are shown only by the bench's scenarios. These are the half-period length for each scaler, the setup, hold and gap lengths with their zero-means-one rule, and the edge and strobe totals. The bench also shows the rounding of every scaler code and the immunity of a running transfer to new launches and to configuration writes.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned WORD_W  = 4 * FIELD_W;

  // field order fixes bit positions: rate 31:24, setup 23:16, hold 15:8, gap 7:0
  typedef struct packed {
    logic [FIELD_W-1:0] rate;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
  } dev_param_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  localparam dev_param_t PARAM_RESET = '{rate: 8'h80, setup: 8'h00, hold: 8'h00, gap: 8'h00};

  function automatic logic [FIELD_W-1:0] floor_pow2(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] r;
    r = FIELD_W'(1);
    for (int i = 0; i < FIELD_W; i++) begin
      if (v[i]) r = FIELD_W'(1) << i;
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_tg_param_bank.sv
module spi_tg_param_bank
  import spi_tg_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned SEL_W   = $clog2(NUM_DEV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  dev_param_t       wr_word_i,
  input  logic [SEL_W-1:0] rd_a_idx_i,
  output dev_param_t       rd_a_o,
  input  logic [SEL_W-1:0] rd_b_idx_i,
  output dev_param_t       rd_b_o
);
  dev_param_t wr_clean;
  dev_param_t bank [NUM_DEV];

  always_comb begin
    wr_clean      = wr_word_i;
    wr_clean.rate = floor_pow2(wr_word_i.rate);
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_ent
    dev_param_t word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= PARAM_RESET;
      end else if (wr_en_i && (wr_idx_i == SEL_W'(g))) begin
        word_q <= wr_clean;
      end
    end
    assign bank[g] = word_q;
  end

  assign rd_a_o = bank[rd_a_idx_i];
  assign rd_b_o = bank[rd_b_idx_i];
endmodule

// File: rtl/spi_tg_rate_gen.sv
module spi_tg_rate_gen #(
  parameter int unsigned ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ACC_W-1:0] step_i,
  output logic             half_tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum         = {1'b0, acc_q} + {1'b0, step_i};
  assign half_tick_o = run_i & sum[ACC_W];

  // phase restarts at zero for every transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else             acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
  import spi_tg_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned SEL_W   = $clog2(NUM_DEV),
  parameter int unsigned LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   dev_sel_i,
  input  logic [LEN_W-1:0]   nbits_i,
  input  logic               cpol_i,
  input  dev_param_t         param_i,
  input  logic               half_tick_i,
  output logic               run_o,
  output logic [FIELD_W-1:0] rate_o,
  output logic               sclk_o,
  output logic [NUM_DEV-1:0] cs_n_o,
  output logic               bit_tick_o,
  output logic               busy_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SEL_W-1:0]   dev_q;
  logic [FIELD_W-1:0] rate_q, hold_q, gap_q;
  logic [LEN_W-1:0]   nbits_q;
  logic               cpol_q, sclk_q, tick_q;
  logic               last, frame;

  function automatic logic [CNT_W-1:0] units8(input logic [FIELD_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] half_periods(input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] m;
    m = (n == '0) ? LEN_W'(1) : n;
    return {m, 1'b0};
  endfunction

  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dev_q   <= '0;
      rate_q  <= 8'h80;
      hold_q  <= '0;
      gap_q   <= '0;
      nbits_q <= '0;
      cpol_q  <= 1'b0;
      sclk_q  <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SETUP;
            dev_q   <= dev_sel_i;
            rate_q  <= param_i.rate;
            hold_q  <= param_i.hold;
            gap_q   <= param_i.gap;
            nbits_q <= nbits_i;
            cpol_q  <= cpol_i;
            sclk_q  <= cpol_i;
            cnt_q   <= units8(param_i.setup);
          end
        end
        ST_SETUP: begin
          if (half_tick_i) begin
            if (last) begin
              state_q <= ST_CLK;
              cnt_q   <= half_periods(nbits_q);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_CLK: begin
          if (half_tick_i) begin
            sclk_q <= ~sclk_q;
            tick_q <= (sclk_q != cpol_q);
            if (last) begin
              state_q <= ST_HOLD;
              cnt_q   <= units8(hold_q);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_HOLD: begin
          if (half_tick_i) begin
            if (last) begin
              state_q <= ST_GAP;
              cnt_q   <= units8(gap_q);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (half_tick_i) begin
            if (last) state_q <= ST_IDLE;
            else      cnt_q   <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign frame = (state_q == ST_SETUP) || (state_q == ST_CLK) || (state_q == ST_HOLD);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign cs_n_o[g] = ~(frame && (dev_q == SEL_W'(g)));
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign run_o      = busy_o;
  assign rate_o     = rate_q;
  assign sclk_o     = sclk_q;
  assign bit_tick_o = tick_q;
endmodule

// File: rtl/spi_cs_timing_gen.sv
module spi_cs_timing_gen
  import spi_tg_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned SEL_W  = $clog2(NUM_DEV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_idx_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   dev_sel_i,
  input  logic [LEN_W-1:0]   nbits_i,
  input  logic               cpol_i,
  output logic               sclk_o,
  output logic [NUM_DEV-1:0] cs_n_o,
  output logic               bit_tick_o,
  output logic               busy_o
);
  dev_param_t         cfg_word, dev_word;
  logic               run, half_tick;
  logic [FIELD_W-1:0] rate;

  spi_tg_param_bank #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_word_i (dev_param_t'(cfg_wdata_i)),
    .rd_a_idx_i(cfg_idx_i),
    .rd_a_o    (cfg_word),
    .rd_b_idx_i(dev_sel_i),
    .rd_b_o    (dev_word)
  );

  spi_tg_rate_gen #(.ACC_W(FIELD_W)) rate_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .step_i     (rate),
    .half_tick_o(half_tick)
  );

  spi_tg_seq #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W), .LEN_W(LEN_W)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dev_sel_i  (dev_sel_i),
    .nbits_i    (nbits_i),
    .cpol_i     (cpol_i),
    .param_i    (dev_word),
    .half_tick_i(half_tick),
    .run_o      (run),
    .rate_o     (rate),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o),
    .bit_tick_o (bit_tick_o),
    .busy_o     (busy_o)
  );

  assign cfg_rdata_o = 32'(cfg_word);
endmodule

// File: rtl/spi_cs_timing_gen_chk.sv
module spi_cs_timing_gen_chk #(
  parameter int unsigned NUM_DEV = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [31:0]        cfg_rdata_o,
  input logic               sclk_o,
  input logic [NUM_DEV-1:0] cs_n_o,
  input logic               bit_tick_o,
  input logic               busy_o
);
  p_scaler_pow2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cfg_rdata_o[31:24]) == 1);

  p_one_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  p_tick_in_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> !(&cs_n_o));

  p_busy_fall_cs_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (&cs_n_o));

  p_cs_implies_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) |-> busy_o);

  p_busy_rise_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_sclk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> !(&cs_n_o));
endmodule

bind spi_cs_timing_gen spi_cs_timing_gen_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cfg_rdata_o(cfg_rdata_o),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o),
  .bit_tick_o (bit_tick_o),
  .busy_o     (busy_o)
);

// File: tb/spi_cs_timing_gen_tb_top.sv
module spi_cs_timing_gen_tb_top;
  localparam int NDEV  = 8;
  localparam int LEN_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [2:0]       cfg_idx_i = '0;
  logic [31:0]      cfg_wdata_i = '0;
  logic [31:0]      cfg_rdata_o;
  logic             start_i = 1'b0;
  logic [2:0]       dev_sel_i = '0;
  logic [LEN_W-1:0] nbits_i = '0;
  logic             cpol_i = 1'b0;
  logic             sclk_o;
  logic [NDEV-1:0]  cs_n_o;
  logic             bit_tick_o;
  logic             busy_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [NDEV];

  spi_cs_timing_gen #(.NUM_DEV(NDEV), .LEN_W(LEN_W)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd(input logic [7:0] v);
    logic [7:0] r = 8'd1;
    for (int i = 0; i < 8; i++) if (int'(v) >= (1 << i)) r = 8'(1 << i);
    return r;
  endfunction

  function automatic int unit(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic write_word(input int dev, input logic [31:0] w);
    @(negedge clk_i);
    cfg_idx_i = 3'(dev); cfg_wdata_i = w; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model[dev] = {rnd(w[31:24]), w[23:0]};
  endtask

  // mode 0: plain, 1: extra launch mid-transfer, 2: config write mid-transfer
  task automatic run_txn(input int dev, input int n, input bit cpol, input int mode,
                         input logic [31:0] alt);
    int h, sp, hp, gp, np, i, busy_n, cs_n, tog, ticks, first, last_tog;
    int other_bad, idle_bad, per_bad, tick_bad;
    logic prev;
    h  = 256 / int'(model[dev][31:24]);
    sp = unit(int'(model[dev][23:16]));
    hp = unit(int'(model[dev][15:8]));
    gp = unit(int'(model[dev][7:0]));
    np = unit(n);
    @(negedge clk_i);
    dev_sel_i = 3'(dev); nbits_i = LEN_W'(n); cpol_i = cpol; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    i = 0; busy_n = 0; cs_n = 0; tog = 0; ticks = 0; first = -1; last_tog = -1;
    other_bad = 0; idle_bad = 0; per_bad = 0; tick_bad = 0; prev = cpol;
    while (busy_o && i < 100000) begin
      busy_n++;
      if (!cs_n_o[dev]) cs_n++;
      for (int d = 0; d < NDEV; d++) if (d != dev && !cs_n_o[d]) other_bad++;
      if (sclk_o != prev) begin
        tog++;
        if (first < 0) first = i;
        if (last_tog >= 0 && (i - last_tog) != h) per_bad++;
        last_tog = i;
      end
      prev = sclk_o;
      if ((i < (sp + 1) * h || i >= (sp + 2 * np) * h) && sclk_o != cpol) idle_bad++;
      if (bit_tick_o) begin
        ticks++;
        if (sclk_o != cpol) tick_bad++;
      end
      if (i == 3) begin
        if (mode == 1) begin
          dev_sel_i = 3'((dev + 1) % NDEV); start_i = 1'b1;
        end else if (mode == 2) begin
          cfg_idx_i = 3'(dev); cfg_wdata_i = alt; cfg_we_i = 1'b1;
        end
      end
      if (i == 4) begin
        start_i = 1'b0; cfg_we_i = 1'b0;
      end
      @(negedge clk_i);
      i++;
    end
    start_i = 1'b0; cfg_we_i = 1'b0;
    chk(busy_n == (sp + 2 * np + hp + gp) * h, "R8 busy length", busy_n, (sp + 2 * np + hp + gp) * h);
    chk(cs_n == (sp + 2 * np + hp) * h, "R7 select low length", cs_n, (sp + 2 * np + hp) * h);
    chk(first == (sp + 1) * h, "R5 first clock edge", first, (sp + 1) * h);
    chk(tog == 2 * np, "R6 clock edge count", tog, 2 * np);
    chk(ticks == np, "R6 bit tick count", ticks, np);
    chk(tick_bad == 0, "R6 tick at idle level", tick_bad, 0);
    chk(per_bad == 0, "R3 half period spacing", per_bad, 0);
    chk(other_bad == 0, "R4 other select low", other_bad, 0);
    chk(idle_bad == 0, "R9 clock off idle", idle_bad, 0);
    for (int k = 0; k < 3; k++) begin
      chk(!busy_o && (&cs_n_o), "R8 no late launch", int'(busy_o), 0);
      @(negedge clk_i);
    end
    if (mode == 2) model[dev] = {rnd(alt[31:24]), alt[23:0]};
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDEV; d++) model[d] = 32'h8000_0000;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(cs_n_o == 8'hFF, "R11 selects high", int'(cs_n_o), 255);
    chk(!sclk_o && !busy_o && !bit_tick_o, "R11 outputs low", int'({sclk_o, busy_o, bit_tick_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int d = 0; d < NDEV; d++) begin
      cfg_idx_i = 3'(d);
      #1;
      chk(cfg_rdata_o == 32'h8000_0000, "R11 reset word", int'(cfg_rdata_o), 32'h8000_0000);
    end
    // R1 R2 every scaler code, spread over all devices
    for (int v = 0; v < 256; v++) begin
      write_word(v % NDEV, {8'(v), 8'(v ^ 8'h5A), 8'(v + 3), 8'(255 - v)});
      chk(cfg_rdata_o == model[v % NDEV], "R2 scaler rounding", int'(cfg_rdata_o), int'(model[v % NDEV]));
    end
    for (int d = 0; d < NDEV; d++) write_word(d, {8'(1 << d), 8'(d), 8'(d + 16), 8'(d + 32)});
    for (int d = 0; d < NDEV; d++) begin
      cfg_idx_i = 3'(d);
      #1;
      chk(cfg_rdata_o == model[d], "R1 per-device readback", int'(cfg_rdata_o), int'(model[d]));
    end
    // R3 every scaler, small counts, both polarities
    for (int k = 0; k < 8; k++) begin
      write_word(k, {8'(1 << k), 8'(k % 3), 8'((k + 1) % 3), 8'((2 * k) % 4)});
      run_txn(k, k % 3, k[0], 0, 32'h0);
    end
    // R5 R6 R7 R8 count sweep at the fastest rate
    foreach (model[d]) begin end
    for (int s = 0; s < 2; s++)
      for (int hd = 0; hd < 2; hd++)
        for (int g = 0; g < 2; g++)
          for (int nn = 0; nn < 3; nn++) begin
            write_word(5, {8'h80, 8'(s * 3), 8'(hd * 2), 8'(g * 5)});
            run_txn(5, (nn == 0) ? 0 : (nn == 1) ? 1 : 7, nn[0], 0, 32'h0);
          end
    // R2 rounded scaler used for timing: 0x60 runs as 64
    write_word(2, 32'h6002_0103);
    run_txn(2, 3, 1'b1, 0, 32'h0);
    // R8 launch while busy ignored
    write_word(6, 32'h4001_0202);
    run_txn(6, 2, 1'b0, 1, 32'h0);
    // R10 config write during transfer
    write_word(3, 32'h2002_0101);
    run_txn(3, 2, 1'b1, 2, 32'h8007_0707);
    run_txn(3, 1, 1'b0, 0, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule